// File: doc/BRIEF.md
# Two-Stage Real-Time Clock Prescaler

This block divides a slow real-time reference clock in two cascaded stages. The first stage is a programmable divider. It emits a one-cycle intermediate tick once every (A + 1) reference cycles, where A is the first divisor. Each intermediate tick steps a binary subsecond downcounter. When that counter is at zero, it reloads from the second divisor S, and the same cycle carries a one-cycle calendar tick. The calendar tick therefore repeats every (A + 1) × (S + 1) reference cycles. With the reset divisors (A = 127, S = 255) and a 32.768 kHz reference, the calendar tick is exactly 1 Hz.

The current subsecond count is an output. Downstream logic can read it as a fine timestamp within the current second. New divisor values are applied through a single-cycle load strobe. The strobe restarts both stages, so the first period after it uses the new values in full. Both ticks are enables in the reference clock domain, not derived clocks.

Top module: `rtc_prescale_chain`

## Requirements
- R1: After reset the divisors are A = 127 and S = 255, the subsecond count reads 255, and both ticks are low until the first intermediate period ends.
- R2: Counting reference cycles from c = 0, the first cycle after reset or after a load, `tick_async` is high exactly in cycles where c mod (A + 1) = A.
- R3: The subsecond count starts at S. It drops by one in the cycle after each intermediate tick at which it is nonzero. It reloads S in the cycle after an intermediate tick at which it is zero. In all other cycles it holds.
- R4: `tick_cal` is high exactly in cycles where `tick_async` is high and the subsecond count is zero, so its period is (A + 1) × (S + 1) cycles.
- R5: With A = 0 and S = 0 the total division is 1, and both ticks are high on every cycle that is not a load cycle.
- R6: A cycle with `load` high captures `div_a_in` and `div_s_in`. The next cycle starts at c = 0 with the subsecond count equal to the new S.
- R7: In a cycle with `load` high, both `tick_async` and `tick_cal` are low.
- R8: While `load` is low, changes on `div_a_in` and `div_s_in` have no effect on the ticks or on the subsecond count.
- R9: With the reset divisors the first calendar tick falls at c = 32767, giving 1 Hz from a 32.768 kHz reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_a_in | input | 7 | New first-stage divisor A, taken on `load` |
| div_s_in | input | 15 | New second-stage divisor S, taken on `load` |
| load | input | 1 | Single-cycle strobe that captures both divisors and restarts the chain |
| tick_async | output | 1 | Intermediate tick, one cycle every A + 1 cycles |
| tick_cal | output | 1 | Calendar tick, one cycle every (A + 1)(S + 1) cycles |
| subsec | output | 15 | Current subsecond downcounter value |

## Verification
The hardest situations to reach are a load that lands partway through both stages, and the degenerate A = 0 or S = 0 cases where the ticks come on consecutive cycles. The stimulus sweeps every pairing of small A and S values back to back. Each new load therefore interrupts the previous configuration mid-period, and the bench compares every cycle against closed-form expressions in c. While `load` is low, the bench keeps changing the divisor inputs. A long run with the reset divisors reaches the full 32768-cycle calendar period.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;
    localparam int unsigned DIV_A_W   = 7;
    localparam int unsigned DIV_S_W   = 15;
    localparam int unsigned DIV_A_RST = 127;
    localparam int unsigned DIV_S_RST = 255;
endpackage

// File: rtl/rtc_async_div.sv
module rtc_async_div #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] div,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == div);
        tick   = at_end && !clr;
        if (clr || at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> st_q.cnt <= div);

    // R2
    wrap_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> st_q.cnt == '0);
endmodule

// File: rtl/rtc_subsec_ctr.sv
module rtc_subsec_ctr #(
    parameter int unsigned W   = 15,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] reload_val,
    input  logic         step,
    output logic         tick,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   empty;

    always_comb begin
        st_d  = st_q;
        empty = (st_q.cnt == '0);
        tick  = step && empty && !clr;
        if (clr) begin
            st_d.cnt = reload_val;
        end else if (step) begin
            st_d.cnt = empty ? reload_val : st_q.cnt - 1'b1;
        end
        count = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= RST;
        else        st_q     <= st_d;
    end

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(st_q.cnt));
endmodule

// File: rtl/rtc_prescale_chain.sv
module rtc_prescale_chain
    import rtc_pre_pkg::*;
#(
    parameter int unsigned A_W   = DIV_A_W,
    parameter int unsigned S_W   = DIV_S_W,
    parameter int unsigned A_RST = DIV_A_RST,
    parameter int unsigned S_RST = DIV_S_RST
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] div_a_in,
    input  logic [S_W-1:0] div_s_in,
    input  logic           load,
    output logic           tick_async,
    output logic           tick_cal,
    output logic [S_W-1:0] subsec
);
    localparam logic [A_W-1:0] A_INIT = A_W'(A_RST);
    localparam logic [S_W-1:0] S_INIT = S_W'(S_RST);

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [S_W-1:0] s;
    } div_t;

    div_t           dv_d, dv_q;
    logic [S_W-1:0] reload_val;

    always_comb begin
        dv_d = dv_q;
        if (load) begin
            dv_d.a = div_a_in;
            dv_d.s = div_s_in;
        end
        reload_val = load ? div_s_in : dv_q.s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q.a <= A_INIT;
            dv_q.s <= S_INIT;
        end else begin
            dv_q <= dv_d;
        end
    end

    rtc_async_div #(.W(A_W)) u_async (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .div   (dv_q.a),
        .tick  (tick_async)
    );

    rtc_subsec_ctr #(.W(S_W), .RST(S_INIT)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (load),
        .reload_val (reload_val),
        .step       (tick_async),
        .tick       (tick_cal),
        .count      (subsec)
    );

    // R4
    cal_needs_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cal |-> (tick_async && subsec == '0));

    // R3
    step_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_async && subsec != '0) |=> subsec == $past(subsec) - 1'b1);

    // R6
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> subsec == $past(div_s_in));

    // R7
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!tick_async && !tick_cal));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (dv_q.a == $past(dv_q.a) && dv_q.s == $past(dv_q.s)));
endmodule

// File: tb/sim_rtc_prescale_chain.sv
module sim_rtc_prescale_chain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  div_a_in = '0;
    logic [14:0] div_s_in = '0;
    logic        load = 1'b0;
    logic        tick_async, tick_cal;
    logic [14:0] subsec;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_prescale_chain u0 (
        .clk(clk), .rst_n(rst_n), .div_a_in(div_a_in), .div_s_in(div_s_in),
        .load(load), .tick_async(tick_async), .tick_cal(tick_cal), .subsec(subsec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // called at a negedge; checks c = 0 .. n-1 relative to the last load or reset
    task automatic run_check(input int a, input int s, input int n, input bit scramble);
        for (int c = 0; c < n; c++) begin
            int ea, es, ev;
            #1;
            ea = ((c % (a + 1)) == a) ? 1 : 0;
            ev = s - ((c / (a + 1)) % (s + 1));
            es = (ea == 1 && ev == 0) ? 1 : 0;
            chk(int'(tick_async) == ea, "R2 tick_async", int'(tick_async), ea);
            chk(int'(subsec) == ev, "R3 subsec", int'(subsec), ev);
            if (a == 127 && s == 255 && c == 32767)
                chk(tick_cal == 1'b1, "R9 first calendar tick", int'(tick_cal), 1);
            else if (a == 0 && s == 0)
                chk(tick_cal == 1'b1 && tick_async == 1'b1, "R5 unit division",
                    int'(tick_cal), 1);
            else
                chk(int'(tick_cal) == es, "R4 tick_cal", int'(tick_cal), es);
            // R8: divisor inputs wander while load is low
            if (scramble) begin
                div_a_in = 7'(c * 37 + 5);
                div_s_in = 15'(c * 101 + 3);
            end
            @(negedge clk);
        end
    endtask

    task automatic do_load(input int a, input int s);
        div_a_in = 7'(a);
        div_s_in = 15'(s);
        load = 1'b1;
        #1;
        chk(tick_async == 1'b0, "R7 tick_async in load cycle", int'(tick_async), 0);
        chk(tick_cal == 1'b0, "R7 tick_cal in load cycle", int'(tick_cal), 0);
        @(negedge clk);
        load = 1'b0;
        #1;
        chk(int'(subsec) == s, "R6 subsec after load", int'(subsec), s);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(int'(subsec) == 255, "R1 subsec reset", int'(subsec), 255);
        chk(tick_async == 1'b0 && tick_cal == 1'b0, "R1 ticks reset",
            int'(tick_async) + int'(tick_cal), 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R1/R9 default divisors over more than one calendar period, inputs wandering (R8)
        run_check(127, 255, 32768 + 300, 1'b1);
        // sweep of small configurations; each load interrupts the previous one mid-period
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 5; s++) begin
                @(negedge clk);
                do_load(a, s);
                @(negedge clk);
                do_load(a, s);
                run_check(a, s, 2 * (a + 1) * (s + 1) + 3, 1'b1);
            end
        end
        // R5 unit division, inputs held stable
        @(negedge clk);
        do_load(0, 0);
        run_check(0, 0, 8, 1'b0);
        // a larger configuration interrupted partway through
        @(negedge clk);
        do_load(9, 20);
        run_check(9, 20, 77, 1'b1);
        do_load(2, 3);
        run_check(2, 3, 30, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule